// File: doc/BRIEF.md
# Single-Cycle Load/Store/Branch Core

A 32-bit processor core that completes every instruction in one clock period. It has three real instructions: a word load, a word store and a branch taken on register equality. Any other opcode acts as a no-op. Fetch, decode, register read, the ALU operation and the choice of next PC all settle combinationally within the period. The PC, the register file and the data memory then commit together on the rising clock edge.

The core holds its own instruction memory and data memory, a 32-entry register file, a shared ALU, an immediate sign extender and the next-PC selector. A preload port fills either memory one word at a time, normally while reset is held. Two debug outputs expose the current PC and any one register, chosen by a select input. Instructions are 32 bits wide. Bits [31:26] are the opcode, [25:21] the base or first source register, [20:16] the data, destination or second source register, and [15:0] a signed 16-bit immediate.

Top module: `lsb_core`

## Requirements
- R1: Opcode 6'h23 (load) reads the data word at byte address reg[25:21] + sext(imm) and writes it into the register named by bits [20:16].
- R2: Opcode 6'h2B (store) writes the value of register [20:16] to the data word at byte address reg[25:21] + sext(imm), and changes no register.
- R3: Opcode 6'h04 (branch) compares registers [25:21] and [20:16] by subtraction. When they are equal, the next PC is PC + 4 + sext(imm), where imm is a byte offset and may be negative.
- R4: A branch whose registers differ moves the PC to PC + 4.
- R5: Loads, stores and every opcode other than the three above advance the PC by exactly 4, and the PC stays word aligned.
- R6: Bits [1:0] of a data address are ignored, so byte addresses 4k to 4k+3 all reach data word k.
- R7: Register 0 always reads as zero, and a load that targets it changes nothing.
- R8: A load whose destination is also its base register forms its address from the base value held before the instruction.
- R9: Synchronous active-high reset sets the PC to 0 on the next rising edge and holds it there. Reset clears neither the register file nor the data memory, and no instruction commits while reset is high.
- R10: When prog_we is high at a rising edge, prog_wdata is written to word prog_addr of the data memory if prog_sel_data is 1, or of the instruction memory if it is 0.
- R11: dbg_pc shows the current PC, and dbg_reg_data combinationally shows the register chosen by dbg_reg_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Preload write strobe |
| prog_sel_data | input | 1 | Preload target: 1 selects data memory, 0 selects instruction memory |
| prog_addr | input | PAW (6) | Word index for the preload write |
| prog_wdata | input | 32 | Word to preload |
| dbg_reg_sel | input | 5 | Register picked for dbg_reg_data |
| dbg_reg_data | output | 32 | Value of the selected register |
| dbg_pc | output | 32 | Current program counter |

## Verification
The hardest outcomes to observe from the ports are the ones where nothing happens. A store must leave its data register untouched. A taken branch must really skip the instructions it jumps over. A load into register 0 must have no effect. The program is built so that each of these would leave a visible mark if it went wrong. The skipped instructions would overwrite a register that is checked later. The store targets a word preloaded with zero, so a wrongly committed load would zero the store's data register. The load into register 0 reads a non-zero word. Reset retention is checked by asserting reset in the middle of a run and then rerunning the program to read back words that were stored before the reset.

// File: rtl/lsb_core_pkg.sv
package lsb_core_pkg;

    localparam int XLEN      = 32;
    localparam int REG_COUNT = 32;
    localparam int RIDX_W    = $clog2(REG_COUNT);

    localparam logic [5:0] OPC_LOAD   = 6'h23;
    localparam logic [5:0] OPC_STORE  = 6'h2B;
    localparam logic [5:0] OPC_BRANCH = 6'h04;

    typedef enum logic [1:0] {
        K_NOP,
        K_LOAD,
        K_STORE,
        K_BRANCH
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [RIDX_W-1:0] rs1;
        logic [RIDX_W-1:0] rt;
        logic [XLEN-1:0]   imm;
    } decoded_t;

    typedef struct packed {
        logic              we;
        logic [RIDX_W-1:0] idx;
        logic [XLEN-1:0]   data;
    } rf_write_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic decoded_t decode(input logic [XLEN-1:0] w);
        decoded_t d;
        case (w[31:26])
            OPC_LOAD:   d.kind = K_LOAD;
            OPC_STORE:  d.kind = K_STORE;
            OPC_BRANCH: d.kind = K_BRANCH;
            default:    d.kind = K_NOP;
        endcase
        d.rs1 = w[25:21];
        d.rt  = w[20:16];
        d.imm = sext16(w[15:0]);
        return d;
    endfunction

endpackage

// File: rtl/lsb_word_ram.sv
module lsb_word_ram
    import lsb_core_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr,
    output logic [XLEN-1:0] rdata
);

    logic [XLEN-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/lsb_regfile.sv
module lsb_regfile
    import lsb_core_pkg::*;
(
    input  logic              clk,
    input  rf_write_t         wr,
    input  logic [RIDX_W-1:0] ra1,
    input  logic [RIDX_W-1:0] ra2,
    input  logic [RIDX_W-1:0] ra_dbg,
    output logic [XLEN-1:0]   rd1,
    output logic [XLEN-1:0]   rd2,
    output logic [XLEN-1:0]   rd_dbg
);

    logic [XLEN-1:0] regs [REG_COUNT];

    always_ff @(posedge clk) begin
        if (wr.we && (wr.idx != '0)) begin
            regs[wr.idx] <= wr.data;
        end
    end

    assign rd1    = (ra1    == '0) ? '0 : regs[ra1];
    assign rd2    = (ra2    == '0) ? '0 : regs[ra2];
    assign rd_dbg = (ra_dbg == '0) ? '0 : regs[ra_dbg];

endmodule

// File: rtl/lsb_alu.sv
module lsb_alu
    import lsb_core_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            subtract,
    output logic [XLEN-1:0] result,
    output logic            zero
);

    always_comb begin
        if (subtract) begin
            result = a - b;
        end else begin
            result = a + b;
        end
        zero = (result == '0);
    end

endmodule

// File: rtl/lsb_core.sv
module lsb_core
    import lsb_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int PAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic              prog_sel_data,
    input  logic [PAW-1:0]    prog_addr,
    input  logic [XLEN-1:0]   prog_wdata,
    input  logic [RIDX_W-1:0] dbg_reg_sel,
    output logic [XLEN-1:0]   dbg_reg_data,
    output logic [XLEN-1:0]   dbg_pc
);

    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] imem_rdata;
    logic [XLEN-1:0] instr;
    logic            fetch_ok;
    decoded_t        dec;
    logic [XLEN-1:0] rs1_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_out;
    logic            alu_zero;
    logic            is_branch;
    logic            take_branch;
    logic            data_ok;
    logic [XLEN-1:0] dmem_rdata;
    logic [XLEN-1:0] load_data;
    logic            dmem_we;
    logic [DAW-1:0]  dmem_waddr;
    logic [XLEN-1:0] dmem_wdata;
    logic            imem_we;
    rf_write_t       rf_wr;

    // Instruction fetch: outside the memory, or misaligned, fetches a no-op.
    assign imem_we  = prog_we && !prog_sel_data;
    assign fetch_ok = (pc[XLEN-1:IAW+2] == '0) && (pc[1:0] == 2'b00);
    assign instr    = fetch_ok ? imem_rdata : '0;

    lsb_word_ram #(.WORDS(IMEM_WORDS)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (prog_addr[IAW-1:0]),
        .wdata (prog_wdata),
        .raddr (pc[IAW+1:2]),
        .rdata (imem_rdata)
    );

    assign dec = decode(instr);

    lsb_regfile u_rf (
        .clk    (clk),
        .wr     (rf_wr),
        .ra1    (dec.rs1),
        .ra2    (dec.rt),
        .ra_dbg (dbg_reg_sel),
        .rd1    (rs1_val),
        .rd2    (rt_val),
        .rd_dbg (dbg_reg_data)
    );

    // One ALU: adds base and offset for memory ops, subtracts for compare.
    assign is_branch = (dec.kind == K_BRANCH);
    assign alu_b     = is_branch ? rt_val : dec.imm;

    lsb_alu u_alu (
        .a        (rs1_val),
        .b        (alu_b),
        .subtract (is_branch),
        .result   (alu_out),
        .zero     (alu_zero)
    );

    // Data memory: bits [1:0] of the address are dropped for word access.
    assign data_ok    = (alu_out[XLEN-1:DAW+2] == '0);
    assign load_data  = data_ok ? dmem_rdata : '0;

    always_comb begin
        if (prog_we && prog_sel_data) begin
            dmem_we    = 1'b1;
            dmem_waddr = prog_addr[DAW-1:0];
            dmem_wdata = prog_wdata;
        end else begin
            dmem_we    = (dec.kind == K_STORE) && !rst && data_ok;
            dmem_waddr = alu_out[DAW+1:2];
            dmem_wdata = rt_val;
        end
    end

    lsb_word_ram #(.WORDS(DMEM_WORDS)) u_dmem (
        .clk   (clk),
        .we    (dmem_we),
        .waddr (dmem_waddr),
        .wdata (dmem_wdata),
        .raddr (alu_out[DAW+1:2]),
        .rdata (dmem_rdata)
    );

    always_comb begin
        rf_wr.we   = (dec.kind == K_LOAD) && !rst;
        rf_wr.idx  = dec.rt;
        rf_wr.data = load_data;
    end

    // Next-PC selection.
    assign take_branch = is_branch && alu_zero;
    assign pc_plus4    = pc + 32'd4;
    assign pc_next     = take_branch ? (pc_plus4 + dec.imm) : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_next;
        end
    end

    assign dbg_pc = pc;

endmodule

// File: rtl/lsb_core_checker.sv
module lsb_core_checker
    import lsb_core_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc,
    input kind_e             kind,
    input logic [RIDX_W-1:0] rs1_idx,
    input logic [XLEN-1:0]   rs1_val,
    input logic [XLEN-1:0]   rt_val,
    input logic [XLEN-1:0]   imm
);

    assert_pc_reset_R9: assert property (@(posedge clk)
        rst |=> (pc == '0));

    assert_seq_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (kind != K_BRANCH) |=> (pc == $past(pc) + 32'd4));

    assert_pc_aligned_R5: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    assert_branch_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (kind == K_BRANCH && rs1_val == rt_val)
        |=> (pc == $past(pc) + 32'd4 + $past(imm)));

    assert_branch_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (kind == K_BRANCH && rs1_val != rt_val) |=> (pc == $past(pc) + 32'd4));

    assert_zero_reg_R7: assert property (@(posedge clk) disable iff (rst)
        (rs1_idx == '0) |-> (rs1_val == '0));

endmodule

bind lsb_core lsb_core_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (dbg_pc),
    .kind    (dec.kind),
    .rs1_idx (dec.rs1),
    .rs1_val (rs1_val),
    .rt_val  (rt_val),
    .imm     (dec.imm)
);

// File: tb/sim_lsb_core.sv
`timescale 1ns/1ps
module sim_lsb_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic        prog_sel_data = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [31:0] prog_wdata = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_data;
    logic [31:0] dbg_pc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lsb_core u0 (
        .clk           (clk),
        .rst           (rst),
        .prog_we       (prog_we),
        .prog_sel_data (prog_sel_data),
        .prog_addr     (prog_addr),
        .prog_wdata    (prog_wdata),
        .dbg_reg_sel   (dbg_reg_sel),
        .dbg_reg_data  (dbg_reg_data),
        .dbg_pc        (dbg_pc)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] a,
                                        input logic [4:0] b, input logic [15:0] imm);
        return {op, a, b, imm};
    endfunction

    // Row: {pc before the step, register checked after it, its expected value}
    localparam logic [68:0] VEC [16] = '{
        {32'h00, 5'd1, 32'h0000_0008},  // R1 load
        {32'h04, 5'd2, 32'hDEAD_BEEF},  // R1
        {32'h08, 5'd3, 32'h0000_0008},  // R1
        {32'h0C, 5'd4, 32'hDEAD_BEEF},  // R1 base from register
        {32'h10, 5'd2, 32'hDEAD_BEEF},  // R2 store leaves its data register
        {32'h14, 5'd5, 32'hDEAD_BEEF},  // R2 stored word read back
        {32'h18, 5'd3, 32'h1234_5678},  // R8 base overwritten by its own load
        {32'h1C, 5'd0, 32'h0000_0000},  // R7 load into register 0
        {32'h20, 5'd1, 32'h0000_0008},  // R3 taken branch
        {32'h2C, 5'd1, 32'h0000_0008},  // R3 skipped loads left r1 alone; R4 next
        {32'h30, 5'd1, 32'h0000_0008},  // R5 unknown opcode
        {32'h34, 5'd3, 32'h1234_5678},  // R6 store to unaligned address
        {32'h38, 5'd6, 32'h1234_5678},  // R6 load from other unaligned address
        {32'h3C, 5'd7, 32'hA5A5_0000},  // R1 negative offset
        {32'h40, 5'd7, 32'hA5A5_0000},  // R3 backward branch to itself
        {32'h40, 5'd6, 32'h1234_5678}   // R3 loop holds
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_check(input string req, input logic [4:0] r, input logic [31:0] exp);
        dbg_reg_sel = r;
        #0.5;
        check(req, dbg_reg_data, exp);
    endtask

    task automatic preload(input bit to_data, input int idx, input logic [31:0] w);
        @(negedge clk);
        prog_we       = 1'b1;
        prog_sel_data = to_data;
        prog_addr     = idx[5:0];
        prog_wdata    = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] prog [17];
        prog[0]  = enc(6'h23, 5'd0, 5'd1, 16'd4);
        prog[1]  = enc(6'h23, 5'd0, 5'd2, 16'd8);
        prog[2]  = enc(6'h23, 5'd0, 5'd3, 16'd12);
        prog[3]  = enc(6'h23, 5'd1, 5'd4, 16'd0);
        prog[4]  = enc(6'h2B, 5'd1, 5'd2, 16'd28);
        prog[5]  = enc(6'h23, 5'd0, 5'd5, 16'd36);
        prog[6]  = enc(6'h23, 5'd3, 5'd3, 16'd8);
        prog[7]  = enc(6'h23, 5'd0, 5'd0, 16'd16);
        prog[8]  = enc(6'h04, 5'd2, 5'd4, 16'd8);
        prog[9]  = enc(6'h23, 5'd0, 5'd1, 16'd8);
        prog[10] = enc(6'h23, 5'd0, 5'd1, 16'd8);
        prog[11] = enc(6'h04, 5'd1, 5'd2, 16'd100);
        prog[12] = 32'hFC00_0000;
        prog[13] = enc(6'h2B, 5'd0, 5'd3, 16'd41);
        prog[14] = enc(6'h23, 5'd0, 5'd6, 16'd43);
        prog[15] = enc(6'h23, 5'd1, 5'd7, 16'hFFF8);
        prog[16] = enc(6'h04, 5'd0, 5'd0, 16'hFFFC);

        // R10: preload both memories through the port while reset is held
        for (int i = 0; i < 64; i++) begin
            preload(1'b0, i, (i < 17) ? prog[i] : 32'h0);
            preload(1'b1, i, 32'h0);
        end
        preload(1'b1, 0, 32'hA5A5_0000);
        preload(1'b1, 1, 32'h0000_0008);
        preload(1'b1, 2, 32'hDEAD_BEEF);
        preload(1'b1, 3, 32'h0000_0008);
        preload(1'b1, 4, 32'h1234_5678);

        check("R9 pc held at 0 in reset", dbg_pc, 32'h0);
        reg_check("R11 register 0 on debug port", 5'd0, 32'h0);

        rst = 1'b0;
        for (int i = 0; i < 16; i++) begin
            check("R5/R3/R4 pc sequence", dbg_pc, VEC[i][68:37]);
            step();
            reg_check($sformatf("R1-family row %0d", i), VEC[i][36:32], VEC[i][31:0]);
        end
        check("R3 branch-to-self holds pc", dbg_pc, 32'h40);
        reg_check("R4 untaken branch kept r2", 5'd2, 32'hDEAD_BEEF);

        // R9: reset mid-run, PC returns to 0, state retained
        rst = 1'b1;
        step();
        check("R9 pc after reset edge", dbg_pc, 32'h0);
        step();
        step();
        check("R9 pc held during reset", dbg_pc, 32'h0);
        reg_check("R9 register file retained", 5'd3, 32'h1234_5678);
        reg_check("R9 no load commits in reset", 5'd1, 32'h0000_0008);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) step();
        check("R9 pc after restart", dbg_pc, 32'h18);
        reg_check("R9 data memory retained", 5'd5, 32'hDEAD_BEEF);
        step();
        reg_check("R8 base reused after restart", 5'd3, 32'h1234_5678);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule